// File: doc/BRIEF.md
# I2C Command-List Master Sequencer

This block is an I2C bus master that needs no processor help for each byte. Software places a packed command list in a byte-wide command memory and pulses a start strobe. The engine then fetches the list through a combinational read port and runs every transaction it describes. It sends write payloads from the same memory, and it stores received bytes in order into a separate receive memory. When the list is done it raises a one-cycle finish pulse. If the target refuses the address or a payload byte, it raises a one-cycle error pulse and keeps a sticky error code.

A list begins with one target byte, which holds the 7-bit address shifted up one place. After it come one or more command pairs, each a control byte followed by a length-high byte. A write command's payload follows its pair directly. A write-then-read list is a write pair with its payload, then a read pair that asks for a repeated start. The address is never stored twice: the read phase resends the stored address with the direction bit set. The bus is timed by an external quarter-bit `tick`. Each bus bit takes four ticks, and so do START and STOP. The pads are modelled as open-drain pull-down enables plus the SDA input.

Top module: `i2c_cmdq_master`

## Requirements
- R1: The command memory is read from offset 0 on each run. Offset 0 holds the target byte. The address byte sent on the bus is that byte with bit 0 replaced by the direction, where 1 means read.
- R2: The control byte has these bits: bit 7 asks for a (repeated) start, bit 6 selects read, bit 5 asks for STOP, bit 4 ends the list, and bit 3 is last-acknowledge. The transfer length is {length-high byte, control byte bits [2:0]} + 1, for 1 to 2048 bytes.
- R3: Write payload bytes are taken in memory order, starting right after their command pair. Each goes out MSB first, and the ninth-bit acknowledge is sampled from SDA.
- R4: Read bytes are written to receive addresses 0, 1, 2 and on, across the whole list. Every read byte is acknowledged except the final byte of a command. That final byte is NACKed unless last-acknowledge is 1 and STOP is 0.
- R5: The first command, any command with bit 7 set, and any command that follows a STOP each begin with a START and the address byte. Any other command continues on the bus with no start and no address.
- R6: After a command's bytes, a STOP is sent if bit 5 or bit 4 is set. After the STOP of the end-flagged command, `doneIrq` pulses for exactly one cycle and never together with `errIrq`.
- R7: A NACK on the address byte sets `errCode` to 1, and a NACK on a write payload byte sets it to 2. Either one sends a STOP, pulses `errIrq` once and ends the run.
- R8: `errCode` is sticky. While it is nonzero, a start strobe is ignored. `clearErr` while idle returns it to 0.
- R9: `busy` rises in the cycle after an accepted start strobe and stays high until the final STOP completes. A start strobe while busy has no effect.
- R10: After reset and after every run, both pull-down enables are off. START is SDA falling while SCL is released, and STOP is SDA rising while SCL is released.
- R11: `sclOe` and `sdaOe` change only in the cycle right after a cycle with `tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit bus timing strobe |
| startPulse | input | 1 | Begin executing the command list |
| clearErr | input | 1 | Clear the sticky error code while idle |
| cmdAddr | output | CMD_AW | Command memory read address |
| cmdData | input | 8 | Command memory read data, combinational |
| rxWe | output | 1 | Receive memory write enable |
| rxAddr | output | RX_AW | Receive memory write address |
| rxData | output | 8 | Receive memory write data |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A command list is running |
| doneIrq | output | 1 | One-cycle finish pulse |
| errIrq | output | 1 | One-cycle error pulse |
| errCode | output | 2 | Sticky error: 0 none, 1 address NACK, 2 data NACK |

## Verification
The bench models a target on the wires and checks every START, STOP and byte, including its ninth bit, against an expected event list. It targets these corner cases:
- A length that spans both length fields. An engine that drops the high byte stops after two bytes.
- A write-then-read list. Losing the restart, or the direction bit, shows up as a missing START or a wrong address byte.
- A read without STOP but with last-acknowledge set. A misplaced ACK/NACK choice flips the last ninth bit.
- A chained command with no restart. An engine that always re-addresses inserts a spurious START.
- Both NACK kinds, a start strobe while busy, and a start strobe while an error is held. A wrong design would either not raise the error code or run a second transaction.

// File: rtl/i2cq_pkg.sv
`timescale 1ns/1ps
package i2cq_pkg;
  localparam int LEN_W = 11;
  // indices into the flag vector taken from control byte bits [7:3]
  localparam int F_RS = 4;
  localparam int F_RD = 3;
  localparam int F_ST = 2;
  localparam int F_EN = 1;
  localparam int F_LA = 0;
  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_ADDR = 2'd1;
  localparam logic [1:0] ERR_DATA = 2'd2;

  typedef enum logic [2:0] {OP_START, OP_STOP, OP_ADDR, OP_TXD, OP_RX} opKind_e;

  typedef struct packed {
    logic     clrPtrs;
    logic     ldId;
    logic     ldCmdL;
    logic     ldCmdH;
    logic     opGo;
    opKind_e  opKind;
    logic     ackDrive;
    logic     decRem;
    logic     rxWrite;
  } ctl_s;

  typedef struct packed {
    logic       opDone;
    logic       nackSeen;
    logic       remZero;
    logic [4:0] flags;
  } stat_s;
endpackage

// File: rtl/i2cq_datapath.sv
`timescale 1ns/1ps
module i2cq_datapath
  import i2cq_pkg::*;
#(
  parameter int CMD_AW = 8,
  parameter int RX_AW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  ctl_s              ctl,
  output stat_s             stat,
  output logic [CMD_AW-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              rxWe,
  output logic [RX_AW-1:0]  rxAddr,
  output logic [7:0]        rxData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [CMD_AW-1:0] cmdPtr;
  logic [RX_AW-1:0]  rxPtr;
  logic [7:0]        idReg;
  logic [7:0]        cmdLReg;
  logic [LEN_W-1:0]  rem;

  logic        active;
  logic [1:0]  phase;
  logic [3:0]  bitIdx;
  opKind_e     kind;
  logic [7:0]  shift;
  logic        ackReg;
  logic        nackReg;
  logic        sclLow;
  logic        sdaLow;
  logic        opDone;

  logic lastBit;
  logic isRx;
  assign lastBit = (bitIdx == ACK_SLOT);
  assign isRx    = (kind == OP_RX);

  // command/receive pointers and latched command fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPtr  <= '0;
      rxPtr   <= '0;
      idReg   <= '0;
      cmdLReg <= '0;
      rem     <= '0;
    end else begin
      if (ctl.clrPtrs) begin
        cmdPtr <= '0;
        rxPtr  <= '0;
      end else begin
        if (ctl.ldId || ctl.ldCmdL || ctl.ldCmdH ||
            (ctl.opGo && ctl.opKind == OP_TXD))
          cmdPtr <= cmdPtr + 1'b1;
        if (ctl.rxWrite)
          rxPtr <= rxPtr + 1'b1;
      end
      if (ctl.ldId)   idReg   <= cmdData;
      if (ctl.ldCmdL) cmdLReg <= cmdData;
      if (ctl.ldCmdH)      rem <= {cmdData, cmdLReg[2:0]};
      else if (ctl.decRem) rem <= rem - 1'b1;
    end
  end

  // quarter-phase bus engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      phase   <= '0;
      bitIdx  <= '0;
      kind    <= OP_START;
      shift   <= '0;
      ackReg  <= 1'b0;
      nackReg <= 1'b0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
      opDone  <= 1'b0;
    end else begin
      opDone <= 1'b0;
      if (ctl.opGo) begin
        active <= 1'b1;
        phase  <= '0;
        bitIdx <= '0;
        kind   <= ctl.opKind;
        ackReg <= ctl.ackDrive;
        if (ctl.opKind == OP_ADDR)
          shift <= idReg | {7'd0, cmdLReg[7 - (4 - F_RD)]};
        else if (ctl.opKind == OP_TXD)
          shift <= cmdData;
      end else if (tick && active) begin
        phase <= phase + 1'b1;
        case (kind)
          OP_START: begin
            case (phase)
              2'd0: sdaLow <= 1'b0;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b1;
              default: begin
                sclLow <= 1'b1;
                active <= 1'b0;
                opDone <= 1'b1;
              end
            endcase
          end
          OP_STOP: begin
            case (phase)
              2'd0: sdaLow <= 1'b1;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b0;
              default: begin
                active <= 1'b0;
                opDone <= 1'b1;
              end
            endcase
          end
          default: begin
            case (phase)
              2'd0: sdaLow <= lastBit ? (isRx && ackReg) : (!isRx && !shift[7]);
              2'd1: sclLow <= 1'b0;
              2'd2: begin
                if (lastBit) nackReg <= sdaIn;
                else         shift   <= {shift[6:0], sdaIn};
              end
              default: begin
                sclLow <= 1'b1;
                if (lastBit) begin
                  active <= 1'b0;
                  opDone <= 1'b1;
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign stat.opDone   = opDone;
  assign stat.nackSeen = nackReg;
  assign stat.remZero  = (rem == '0);
  assign stat.flags    = cmdLReg[7:3];

  assign cmdAddr = cmdPtr;
  assign rxWe    = ctl.rxWrite;
  assign rxAddr  = rxPtr;
  assign rxData  = shift;
  assign sclOe   = sclLow;
  assign sdaOe   = sdaLow;
endmodule

// File: rtl/i2cq_control.sv
`timescale 1ns/1ps
module i2cq_control
  import i2cq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       clearErr,
  input  stat_s      stat,
  output ctl_s       ctl,
  output logic       busy,
  output logic       doneIrq,
  output logic       errIrq,
  output logic [1:0] errCode
);
  typedef enum logic [2:0] {
    S_IDLE, S_LD_ID, S_LD_CL, S_LD_CH, S_START, S_ADDR, S_DATA, S_STOP
  } state_e;

  state_e state;
  logic   issued;
  logic   addrDue;
  logic   errPend;
  logic   accept;
  logic   isRead;

  assign accept = (state == S_IDLE) && startPulse && (errCode == ERR_NONE);
  assign isRead = stat.flags[F_RD];

  always_comb begin
    ctl = '0;
    ctl.opKind = OP_START;
    case (state)
      S_IDLE:  ctl.clrPtrs = accept;
      S_LD_ID: ctl.ldId    = 1'b1;
      S_LD_CL: ctl.ldCmdL  = 1'b1;
      S_LD_CH: ctl.ldCmdH  = 1'b1;
      S_START: ctl.opGo    = !issued;
      S_ADDR: begin
        ctl.opGo   = !issued;
        ctl.opKind = OP_ADDR;
      end
      S_DATA: begin
        ctl.opGo     = !issued;
        ctl.opKind   = isRead ? OP_RX : OP_TXD;
        ctl.ackDrive = !stat.remZero || (stat.flags[F_LA] && !stat.flags[F_ST]);
        ctl.rxWrite  = stat.opDone && isRead;
        ctl.decRem   = stat.opDone && !stat.remZero && (isRead || !stat.nackSeen);
      end
      S_STOP: begin
        ctl.opGo   = !issued;
        ctl.opKind = OP_STOP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      issued  <= 1'b0;
      addrDue <= 1'b0;
      errPend <= 1'b0;
      errCode <= ERR_NONE;
      doneIrq <= 1'b0;
      errIrq  <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      errIrq  <= 1'b0;
      if (ctl.opGo) issued <= 1'b1;
      if (stat.opDone) issued <= 1'b0;
      case (state)
        S_IDLE: begin
          if (clearErr) errCode <= ERR_NONE;
          if (accept) begin
            state   <= S_LD_ID;
            addrDue <= 1'b1;
          end
        end
        S_LD_ID: state <= S_LD_CL;
        S_LD_CL: state <= S_LD_CH;
        S_LD_CH: begin
          addrDue <= 1'b0;
          state   <= (addrDue || stat.flags[F_RS]) ? S_START : S_DATA;
        end
        S_START: if (stat.opDone) state <= S_ADDR;
        S_ADDR: begin
          if (stat.opDone) begin
            if (stat.nackSeen) begin
              errCode <= ERR_ADDR;
              errPend <= 1'b1;
              state   <= S_STOP;
            end else begin
              state <= S_DATA;
            end
          end
        end
        S_DATA: begin
          if (stat.opDone) begin
            if (!isRead && stat.nackSeen) begin
              errCode <= ERR_DATA;
              errPend <= 1'b1;
              state   <= S_STOP;
            end else if (stat.remZero) begin
              state <= (stat.flags[F_ST] || stat.flags[F_EN]) ? S_STOP : S_LD_CL;
            end
          end
        end
        S_STOP: begin
          if (stat.opDone) begin
            if (errPend) begin
              errPend <= 1'b0;
              errIrq  <= 1'b1;
              state   <= S_IDLE;
            end else if (stat.flags[F_EN]) begin
              doneIrq <= 1'b1;
              state   <= S_IDLE;
            end else begin
              addrDue <= 1'b1;
              state   <= S_LD_CL;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/i2c_cmdq_master.sv
`timescale 1ns/1ps
module i2c_cmdq_master
  import i2cq_pkg::*;
#(
  parameter int CMD_AW = 8,
  parameter int RX_AW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              startPulse,
  input  logic              clearErr,
  output logic [CMD_AW-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              rxWe,
  output logic [RX_AW-1:0]  rxAddr,
  output logic [7:0]        rxData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              doneIrq,
  output logic              errIrq,
  output logic [1:0]        errCode
);
  ctl_s  ctl;
  stat_s stat;

  i2cq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .clearErr   (clearErr),
    .stat       (stat),
    .ctl        (ctl),
    .busy       (busy),
    .doneIrq    (doneIrq),
    .errIrq     (errIrq),
    .errCode    (errCode)
  );

  i2cq_datapath #(.CMD_AW(CMD_AW), .RX_AW(RX_AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .ctl     (ctl),
    .stat    (stat),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .rxWe    (rxWe),
    .rxAddr  (rxAddr),
    .rxData  (rxData),
    .sdaIn   (sdaIn),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe)
  );
endmodule

// File: rtl/i2cq_checker.sv
`timescale 1ns/1ps
module i2cq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       startPulse,
  input logic       clearErr,
  input logic       rxWe,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       busy,
  input logic       doneIrq,
  input logic       errIrq,
  input logic [1:0] errCode
);
  AST_PINS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick) |-> ($stable(sclOe) && $stable(sdaOe))); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe)); // R10
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(doneIrq && errIrq)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 2'd0 && !clearErr) |=> (errCode == $past(errCode))); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse)); // R9
  AST_RX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rxWe |-> busy); // R4
endmodule

bind i2c_cmdq_master i2cq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .startPulse (startPulse),
  .clearErr   (clearErr),
  .rxWe       (rxWe),
  .sclOe      (sclOe),
  .sdaOe      (sdaOe),
  .busy       (busy),
  .doneIrq    (doneIrq),
  .errIrq     (errIrq),
  .errCode    (errCode)
);

// File: tb/tb_i2c_cmdq_master.sv
`timescale 1ns/1ps
module tb_i2c_cmdq_master;
  localparam int EV_START = 32'h1000;
  localparam int EV_STOP  = 32'h2000;
  localparam logic [7:0] RS = 8'h80, RD = 8'h40, ST = 8'h20, EN = 8'h10, LA = 8'h08;
  localparam int PH_NONE = 0, PH_ADDR = 1, PH_WR = 2, PH_RD = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, tick = 1'b0, startPulse = 1'b0, clearErr = 1'b0;
  logic [7:0] cmdAddr, cmdData, rxData;
  logic [7:0] rxAddr;
  logic       rxWe, sdaIn, sclOe, sdaOe, busy, doneIrq, errIrq;
  logic [1:0] errCode;
  logic       tgtLow = 1'b0;

  logic [7:0] cmem [0:255];
  logic [7:0] rxm  [0:255];

  assign cmdData = cmem[cmdAddr];
  assign sdaIn   = !(sdaOe || tgtLow);
  always @(posedge clk) if (rxWe) rxm[rxAddr] <= rxData;

  i2c_cmdq_master dut (
    .clk(clk), .rstN(rstN), .tick(tick), .startPulse(startPulse), .clearErr(clearErr),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rxWe(rxWe), .rxAddr(rxAddr), .rxData(rxData),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .doneIrq(doneIrq),
    .errIrq(errIrq), .errCode(errCode)
  );

  int vecs = 0, bad = 0;
  int expQ[$];
  string tagQ[$];
  int doneCnt = 0, errCnt = 0;

  // target model configuration
  logic [6:0] tAddr = 7'h2A;
  bit nackAddr = 0;
  int nackIdx = -1;

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int v, string t);
    expQ.push_back(v);
    tagQ.push_back(t);
  endtask

  task automatic logEv(int v);
    if (expQ.size() == 0) chk(0, "R10 unexpected bus event", v, -1);
    else begin
      int e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(v == e, t, v, e);
    end
  endtask

  function automatic logic [7:0] rdVal(int k);
    return 8'h90 + 8'(3 * k);
  endfunction

  // tick every fourth clock
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      tick = (c == 0);
    end
  end

  // target and bus monitor: reference for the wire-level behaviour
  bit pScl = 1, pSda = 1, s, d;
  int bc = 0, ph = PH_NONE, wrIdx = 0, rdIdx = 0;
  logic [7:0] sh = 0, rv;
  always @(negedge clk) begin
    s = !sclOe;
    d = !(sdaOe || tgtLow);
    if (rstN) begin
      if (s && pScl && pSda && !d) begin
        logEv(EV_START); bc = 0; ph = PH_ADDR; wrIdx = 0; rdIdx = 0;
      end else if (s && pScl && !pSda && d) begin
        logEv(EV_STOP); ph = PH_NONE;
      end else if (s && !pScl) begin
        if (bc < 8) begin
          sh = {sh[6:0], d}; bc++;
        end else begin
          logEv((d ? 256 : 0) | int'(sh));
          if (ph == PH_ADDR) ph = d ? PH_NONE : (sh[0] ? PH_RD : PH_WR);
          else if (ph == PH_RD) begin
            if (d) ph = PH_NONE; else rdIdx++;
          end
          bc = 0;
        end
      end else if (!s && pScl) begin
        if (bc == 8) begin
          if (ph == PH_ADDR) tgtLow = (sh[7:1] == tAddr) && !nackAddr;
          else if (ph == PH_WR) begin
            tgtLow = (wrIdx != nackIdx);
            wrIdx++;
          end else tgtLow = 1'b0;
        end else if (ph == PH_RD) begin
          rv = rdVal(rdIdx);
          tgtLow = !rv[7 - bc];
        end else tgtLow = 1'b0;
      end
      doneCnt += int'(doneIrq);
      errCnt  += int'(errIrq);
    end
    pScl = s;
    pSda = !(sdaOe || tgtLow);
  end

  task automatic runList(int expDone, int expErr, logic [1:0] expCode, bit midStart, string tag);
    doneCnt = 0; errCnt = 0;
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    if (midStart) begin
      repeat (200) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(expQ.size() == 0, {tag, " missing bus events"}, expQ.size(), 0);
    expQ.delete(); tagQ.delete();
    chk(doneCnt == expDone, "R6 finish pulses", doneCnt, expDone);
    chk(errCnt == expErr, "R7 error pulses", errCnt, expErr);
    chk(errCode == expCode, "R7 error code", int'(errCode), int'(expCode));
    chk(!sclOe && !sdaOe, "R10 lines released", int'({sclOe, sdaOe}), 0);
  endtask

  task automatic clearError();
    @(negedge clk) clearErr = 1'b1;
    @(negedge clk) clearErr = 1'b0;
    chk(errCode == 2'd0, "R8 clear", int'(errCode), 0);
  endtask

  initial begin
    #(5 * 150000);
    vecs++; bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!sclOe && !sdaOe && !busy, "R10 reset state", int'({sclOe, sdaOe, busy}), 0);
    chk(errCode == 0 && !doneIrq && !errIrq, "R10 reset flags", int'(errCode), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 plain write of three bytes, with a start strobe while busy (R9)
    cmem[0] = 8'h54; cmem[1] = ST | EN | 8'd2; cmem[2] = 8'h00;
    cmem[3] = 8'h11; cmem[4] = 8'h22; cmem[5] = 8'h33;
    expect_ev(EV_START, "R5 start");
    expect_ev(32'h054, "R1 address write");
    expect_ev(32'h011, "R3 byte0"); expect_ev(32'h022, "R3 byte1"); expect_ev(32'h033, "R3 byte2");
    expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 1, "R3 write");

    // R4 read of four bytes with STOP
    cmem[1] = RD | ST | EN | 8'd3; cmem[2] = 8'h00;
    expect_ev(EV_START, "R5 start");
    expect_ev(32'h055, "R1 address read");
    for (int k = 0; k < 3; k++) expect_ev(int'(rdVal(k)), "R4 ack read byte");
    expect_ev(256 | int'(rdVal(3)), "R4 final nack");
    expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 0, "R4 read");
    for (int k = 0; k < 4; k++) chk(rxm[k] == rdVal(k), "R4 rx memory", int'(rxm[k]), int'(rdVal(k)));

    // R5 write then read with repeated start, no second target byte
    cmem[1] = 8'h01; cmem[2] = 8'h00; cmem[3] = 8'hAA; cmem[4] = 8'hBB;
    cmem[5] = RS | RD | ST | EN | 8'd2; cmem[6] = 8'h00;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h054, "R1 address write");
    expect_ev(32'h0AA, "R3 w0"); expect_ev(32'h0BB, "R3 w1");
    expect_ev(EV_START, "R5 repeated start"); expect_ev(32'h055, "R5 address resent read");
    expect_ev(int'(rdVal(0)), "R4 r0"); expect_ev(int'(rdVal(1)), "R4 r1");
    expect_ev(256 | int'(rdVal(2)), "R4 r2 nack");
    expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 0, "R5 write-read");
    for (int k = 0; k < 3; k++) chk(rxm[k] == rdVal(k), "R4 rx order", int'(rxm[k]), int'(rdVal(k)));

    // R2 ten-byte write: length-1 = 9 split over both fields
    cmem[1] = ST | EN | 8'd1; cmem[2] = 8'd1;
    for (int k = 0; k < 10; k++) cmem[3 + k] = 8'h40 + 8'(k);
    expect_ev(EV_START, "R5 start"); expect_ev(32'h054, "R1 address");
    for (int k = 0; k < 10; k++) expect_ev(32'h040 + k, "R2 length split");
    expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 0, "R2 long write");

    // R5 chained command without restart continues the same transfer
    cmem[1] = 8'h01; cmem[2] = 8'h00; cmem[3] = 8'h11; cmem[4] = 8'h22;
    cmem[5] = ST | EN | 8'd0; cmem[6] = 8'h00; cmem[7] = 8'h33;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h054, "R1 address");
    expect_ev(32'h011, "R5 c0"); expect_ev(32'h022, "R5 c1"); expect_ev(32'h033, "R5 no restart");
    expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 0, "R5 chained");

    // R4 last-acknowledge without STOP: final byte ACKed, list end still stops (R6)
    cmem[1] = RD | LA | EN | 8'd1; cmem[2] = 8'h00;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h055, "R1 address read");
    expect_ev(int'(rdVal(0)), "R4 r0"); expect_ev(int'(rdVal(1)), "R4 last-ack kept");
    expect_ev(EV_STOP, "R6 stop on end");
    runList(1, 0, 2'd0, 0, "R4 last-ack");

    // R4 no STOP, last-acknowledge clear: final byte NACKed
    cmem[1] = RD | EN | 8'd1;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h055, "R1 address read");
    expect_ev(int'(rdVal(0)), "R4 r0"); expect_ev(256 | int'(rdVal(1)), "R4 last nack");
    expect_ev(EV_STOP, "R6 stop on end");
    runList(1, 0, 2'd0, 0, "R4 nack");

    // R7 address NACK
    nackAddr = 1;
    cmem[1] = ST | EN | 8'd0; cmem[2] = 8'h00; cmem[3] = 8'h77;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h154, "R7 address refused");
    expect_ev(EV_STOP, "R7 stop after nack");
    runList(0, 1, 2'd1, 0, "R7 addr nack");
    nackAddr = 0;

    // R8 start ignored while the error is held
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R8 start ignored", int'(busy), 0);
    chk(errCode == 2'd1, "R8 sticky code", int'(errCode), 1);
    clearError();

    // R7 data NACK on second payload byte
    nackIdx = 1;
    cmem[1] = ST | EN | 8'd2; cmem[3] = 8'h11; cmem[4] = 8'h22; cmem[5] = 8'h33;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h054, "R1 address");
    expect_ev(32'h011, "R3 byte0"); expect_ev(32'h122, "R7 data refused");
    expect_ev(EV_STOP, "R7 stop after data nack");
    runList(0, 1, 2'd2, 0, "R7 data nack");
    nackIdx = -1;
    clearError();

    // R8 run works again after clearing
    cmem[1] = ST | EN | 8'd0; cmem[3] = 8'h5A;
    expect_ev(EV_START, "R5 start"); expect_ev(32'h054, "R1 address");
    expect_ev(32'h05A, "R8 after clear"); expect_ev(EV_STOP, "R6 stop");
    runList(1, 0, 2'd0, 0, "R8 recovered");

    // R11 covered continuously by the bound checker; a final idle check
    chk(!busy, "R9 idle at end", int'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule